// File: doc/BRIEF.md
# Configuration Page Reconfiguration Controller

This controller picks which stored configuration image a downstream programmable device should load. The flash holds up to eight images, one per page, and a 3-bit page select names the one to load. The block issues that page as a load address together with a one-cycle start strobe. It then waits for the configuration side to report either completion or an error.

When a load of an application image reports an error, the controller starts a new load of the protected factory page on its own. No external request is needed for this. It also raises a fallback flag. If the factory image itself fails, the controller stops in a latched fatal state, and only reset clears that state.

A successful load places the target in user mode. From user mode, a high-to-low edge on the active-low reconfigure request starts a load of whatever page is selected at that moment. The boot sequence is as follows: set the page, release reset, and the first load starts on its own. Later page changes use the reconfigure request once the target is in user mode.

Top module: `cfg_page_ctrl`

## Requirements
- R1: Three rising clock edges after `rst_n` goes high, `load_start` is high for exactly one cycle, and `load_page` equals the `page_sel` value present at that third edge.
- R2: `load_done` during a load moves the block to user mode. From then on, `load_start` stays low until a reconfigure request arrives.
- R3: `load_err` during the load of any page other than the factory page (parameter, default 0) causes two things at the next edge: a `load_start` pulse with `load_page` equal to the factory page, and `fallback` going high.
- R4: `load_err` during the load of the factory page sets `fatal`. While `fatal` is high, `load_start` never pulses, and reconfigure requests have no effect. Only driving `rst_n` low clears `fatal`.
- R5: In user mode, a high-to-low transition on `reconf_n` produces a `load_start` pulse on the second rising edge after the low level is applied. `load_page` then equals `page_sel`, and `fallback` is cleared.
- R6: Holding `reconf_n` low produces one reload only. No further `load_start` follows, for as long as the level stays low.
- R7: A falling edge on `reconf_n` is ignored if it occurs while a load is in progress or while `rst_n` is low. No extra `load_start` results from it, either at that time or later.
- R8: `load_page` is captured when a load starts. Changes on `page_sel` during that load do not alter it.
- R9: While `rst_n` is low, `load_start`, `fallback` and `fatal` are 0 and `load_page` shows the factory page. Reset takes effect without a clock.
- R10: When `load_err` and `load_done` arrive in the same cycle, the error wins. `load_err` and `load_done` outside a load are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock; all inputs are synchronous to it |
| rst_n | input | 1 | Active-low reset, asserted asynchronously, released synchronously |
| page_sel | input | 3 | Page of the image to load next |
| reconf_n | input | 1 | Active-low reconfigure request, acted on at its falling edge |
| load_done | input | 1 | Configuration side reports a successful load |
| load_err | input | 1 | Configuration side reports a failed load |
| load_page | output | 3 | Page address of the current or last load |
| load_start | output | 1 | One-cycle strobe starting a load |
| fallback | output | 1 | High after an automatic switch to the factory page |
| fatal | output | 1 | High after the factory image itself failed |

## Verification
The hardest state to reach is the latched fatal state. Reaching it needs an error during the load of the factory page. The bench gets there by booting with the page select already at the factory page and then reporting an error, and it confirms that the state survives a later reconfigure pulse. A second awkward case is an error that arrives in the same cycle as a completion. The bench drives both inputs together on one cycle to show that the fallback load wins.

// File: rtl/cfg_page_pkg.sv
package cfg_page_pkg;

  typedef enum logic [1:0] {
    ST_START = 2'd0,
    ST_LOAD  = 2'd1,
    ST_USER  = 2'd2,
    ST_FATAL = 2'd3
  } cfg_state_e;

endpackage

// File: rtl/cfg_rst_sync.sv
module cfg_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sh_q[STAGES-1];

  AST_RST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rst_sync_n |=> rst_sync_n);  // R9

endmodule

// File: rtl/cfg_req_edge.sv
module cfg_req_edge #(
  parameter int STAGES = 1
) (
  input  logic clk,
  input  logic rst_sync_n,
  input  logic req_n,
  output logic req_fall
);

  logic [STAGES-1:0] pipe_q;
  logic              prev_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_sync_n) begin
          if (!rst_sync_n) pipe_q[0] <= 1'b1;
          else             pipe_q[0] <= req_n;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_sync_n) begin
          if (!rst_sync_n) pipe_q[i] <= 1'b1;
          else             pipe_q[i] <= pipe_q[i-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) prev_q <= 1'b1;
    else             prev_q <= pipe_q[STAGES-1];
  end

  assign req_fall = prev_q & ~pipe_q[STAGES-1];

  AST_FALL_SINGLE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    req_fall |=> !req_fall);  // R6

endmodule

// File: rtl/cfg_page_fsm.sv
module cfg_page_fsm
  import cfg_page_pkg::*;
#(
  parameter int                PAGE_W       = 3,
  parameter logic [PAGE_W-1:0] FACTORY_PAGE = '0
) (
  input  logic              clk,
  input  logic              rst_sync_n,
  input  logic [PAGE_W-1:0] page_sel,
  input  logic              req_fall,
  input  logic              load_done,
  input  logic              load_err,
  output logic [PAGE_W-1:0] load_page,
  output logic              load_start,
  output logic              fallback,
  output logic              fatal
);

  cfg_state_e        state_q, state_d;
  logic [PAGE_W-1:0] page_q, page_nxt;
  logic              page_en;
  logic              start_q, start_d;
  logic              fb_q, fb_d;
  logic              fatal_q, fatal_d;
  logic              on_factory;

  assign on_factory = (page_q == FACTORY_PAGE);

  always_comb begin
    state_d  = state_q;
    page_en  = 1'b0;
    page_nxt = page_q;
    start_d  = 1'b0;
    fb_d     = fb_q;
    fatal_d  = fatal_q;
    unique case (state_q)
      ST_START: begin
        start_d  = 1'b1;
        page_en  = 1'b1;
        page_nxt = page_sel;
        fb_d     = 1'b0;
        state_d  = ST_LOAD;
      end
      ST_LOAD: begin
        if (load_err) begin
          if (on_factory) begin
            fatal_d = 1'b1;
            state_d = ST_FATAL;
          end else begin
            start_d  = 1'b1;
            page_en  = 1'b1;
            page_nxt = FACTORY_PAGE;
            fb_d     = 1'b1;
          end
        end else if (load_done) begin
          state_d = ST_USER;
        end
      end
      ST_USER: begin
        if (req_fall) begin
          start_d  = 1'b1;
          page_en  = 1'b1;
          page_nxt = page_sel;
          fb_d     = 1'b0;
          state_d  = ST_LOAD;
        end
      end
      ST_FATAL: begin
        state_d = ST_FATAL;
      end
      default: state_d = ST_FATAL;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q <= ST_START;
      start_q <= 1'b0;
      fb_q    <= 1'b0;
      fatal_q <= 1'b0;
    end else begin
      state_q <= state_d;
      start_q <= start_d;
      fb_q    <= fb_d;
      fatal_q <= fatal_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  page_q <= FACTORY_PAGE;
    else if (page_en) page_q <= page_nxt;
  end

  assign load_page  = page_q;
  assign load_start = start_q;
  assign fallback   = fb_q;
  assign fatal      = fatal_q;

  AST_FALLBACK_FACTORY: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(fb_q) |-> (start_q && page_q == FACTORY_PAGE));  // R3
  AST_FATAL_LATCHED: assert property (@(posedge clk) disable iff (!rst_sync_n)
    fatal_q |=> fatal_q);  // R4
  AST_FATAL_SILENT: assert property (@(posedge clk) disable iff (!rst_sync_n)
    fatal_q |-> !start_q);  // R4
  AST_PAGE_HELD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (state_q == ST_LOAD && !start_q) |-> $stable(page_q));  // R8
  AST_USER_QUIET: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (state_q == ST_USER && !req_fall) |=> !start_q);  // R2

endmodule

// File: rtl/cfg_page_ctrl.sv
module cfg_page_ctrl #(
  parameter int                PAGE_W       = 3,
  parameter logic [PAGE_W-1:0] FACTORY_PAGE = '0,
  parameter int                RST_STAGES   = 2,
  parameter int                REQ_STAGES   = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PAGE_W-1:0] page_sel,
  input  logic              reconf_n,
  input  logic              load_done,
  input  logic              load_err,
  output logic [PAGE_W-1:0] load_page,
  output logic              load_start,
  output logic              fallback,
  output logic              fatal
);

  logic rst_sync_n;
  logic req_fall;

  cfg_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  cfg_req_edge #(.STAGES(REQ_STAGES)) u_req (
    .clk        (clk),
    .rst_sync_n (rst_sync_n),
    .req_n      (reconf_n),
    .req_fall   (req_fall)
  );

  cfg_page_fsm #(.PAGE_W(PAGE_W), .FACTORY_PAGE(FACTORY_PAGE)) u_fsm (
    .clk        (clk),
    .rst_sync_n (rst_sync_n),
    .page_sel   (page_sel),
    .req_fall   (req_fall),
    .load_done  (load_done),
    .load_err   (load_err),
    .load_page  (load_page),
    .load_start (load_start),
    .fallback   (fallback),
    .fatal      (fatal)
  );

endmodule

// File: tb/sim_cfg_page_ctrl.sv
module sim_cfg_page_ctrl;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n, reconf_n, load_done, load_err;
  logic [2:0] page_sel, load_page;
  logic       load_start, fallback, fatal;
  int         n_chk = 0;
  int         n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_page_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .page_sel(page_sel), .reconf_n(reconf_n),
    .load_done(load_done), .load_err(load_err), .load_page(load_page),
    .load_start(load_start), .fallback(fallback), .fatal(fatal)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic quiet(input int n, input string req);
    for (int i = 0; i < n; i++) begin
      step(1);
      check(load_start == 1'b0, req, load_start, 0);
    end
  endtask

  task automatic finish_load();
    load_done = 1'b1;
    step(1);
    load_done = 1'b0;
  endtask

  task automatic boot(input logic [2:0] pg);
    rst_n = 1'b0; reconf_n = 1'b1; load_done = 1'b0; load_err = 1'b0;
    page_sel = pg;
    step(2);
    check(load_start == 0 && fallback == 0 && fatal == 0, "R9", {load_start, fallback, fatal}, 0);
    check(load_page == 3'd0, "R9", load_page, 0);
    rst_n = 1'b1;
    step(2);
    check(load_start == 1'b0, "R1", load_start, 0);
    step(1);
    check(load_start == 1'b1, "R1", load_start, 1);
    check(load_page == pg, "R1", load_page, pg);
  endtask

  task automatic reconf(input logic [2:0] pg, input string req);
    page_sel = pg;
    reconf_n = 1'b0;
    step(1);
    check(load_start == 1'b0, req, load_start, 0);
    step(1);
    check(load_start == 1'b1, req, load_start, 1);
    check(load_page == pg, req, load_page, pg);
    reconf_n = 1'b1;
  endtask

  task automatic t_boot();
    boot(3'd5);
    step(1);
    check(load_start == 1'b0, "R1", load_start, 0);
    finish_load();
    quiet(5, "R2");
    check(load_page == 3'd5, "R2", load_page, 5);
  endtask

  task automatic t_reconf();
    reconf(3'd3, "R5");
    finish_load();
    quiet(3, "R2");
  endtask

  task automatic t_hold_low();
    page_sel = 3'd6;
    reconf_n = 1'b0;
    step(2);
    check(load_start == 1'b1 && load_page == 3'd6, "R6", load_page, 6);
    finish_load();
    quiet(8, "R6");
    reconf_n = 1'b1;
    quiet(2, "R6");
  endtask

  task automatic t_fallback();
    reconf(3'd2, "R5");
    page_sel = 3'd7;
    step(3);
    check(load_page == 3'd2, "R8", load_page, 2);
    load_err = 1'b1;
    step(1);
    load_err = 1'b0;
    check(load_start == 1'b1, "R3", load_start, 1);
    check(load_page == 3'd0, "R3", load_page, 0);
    check(fallback == 1'b1, "R3", fallback, 1);
    finish_load();
    check(fallback == 1'b1 && fatal == 1'b0, "R3", {fallback, fatal}, 2);
    reconf(3'd4, "R5");
    check(fallback == 1'b0, "R5", fallback, 0);
  endtask

  task automatic t_ignore_load();
    reconf_n = 1'b0;
    step(1);
    reconf_n = 1'b1;
    quiet(4, "R7");
    finish_load();
    quiet(4, "R7");
  endtask

  task automatic t_priority();
    reconf(3'd1, "R5");
    load_done = 1'b1; load_err = 1'b1;
    step(1);
    load_done = 1'b0; load_err = 1'b0;
    check(load_start == 1'b1 && load_page == 3'd0, "R10", load_page, 0);
    check(fallback == 1'b1, "R10", fallback, 1);
    finish_load();
    load_err = 1'b1;
    step(1);
    load_err = 1'b0;
    check(load_start == 1'b0 && fatal == 1'b0, "R10", {load_start, fatal}, 0);
    quiet(2, "R10");
  endtask

  task automatic t_fatal();
    boot(3'd0);
    load_err = 1'b1;
    step(1);
    load_err = 1'b0;
    check(fatal == 1'b1, "R4", fatal, 1);
    check(load_start == 1'b0, "R4", load_start, 0);
    reconf_n = 1'b0;
    step(1);
    reconf_n = 1'b1;
    quiet(4, "R4");
    check(fatal == 1'b1, "R4", fatal, 1);
    rst_n = 1'b0;
    #1;
    check(fatal == 1'b0, "R4", fatal, 0);
  endtask

  task automatic t_reset_ignore();
    rst_n = 1'b0; page_sel = 3'd6;
    step(1);
    reconf_n = 1'b0;
    step(1);
    reconf_n = 1'b1;
    step(1);
    rst_n = 1'b1;
    step(3);
    check(load_start == 1'b1 && load_page == 3'd6, "R7", load_page, 6);
    finish_load();
    quiet(5, "R7");
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_fail++;
    $display("FAIL watchdog: actual 0 expected 1 (run did not complete)");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; reconf_n = 1'b1; load_done = 1'b0; load_err = 1'b0; page_sel = '0;
    step(1);
    t_boot();
    t_reconf();
    t_hold_low();
    t_fallback();
    t_ignore_load();
    t_priority();
    t_fatal();
    t_reset_ignore();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule